// File: doc/BRIEF.md
# Privileged Configuration Register Read Unit

This block carries out one privileged read from a small bank of 64-bit configuration registers. Each register sits at a 32-bit address taken from a parameter table. A request brings an index operand, the current privilege level, the real-address and virtual-8086 mode flags, and a lock-prefix flag. The unit looks up the index and checks the request against a fixed-priority list of faults. One clock later it reports one outcome: either the selected register split into two zero-extended 64-bit destination values, or a single exception with its code.

Execution logic uses the block as a self-contained read engine. The high 32 bits of the register go to the high destination and the low 32 bits go to the low destination. The destinations keep their earlier contents whenever a request faults. A preload port writes a full 64-bit value into any slot of the bank. Each slot has an implemented-bits mask, and bits outside that mask always read back as zero.

Top module: `mrr_read_unit`

## Requirements
- R1: Only bits 31:0 of the 64-bit `index` select the register. Bits 63:32 have no effect on the lookup or on the result.
- R2: On a successful read, `rd_hi` equals the register's bits 63:32 and `rd_lo` equals its bits 31:0. Bits 63:32 of both `rd_hi` and `rd_lo` are zero.
- R3: A request with `lock_pfx` set raises the invalid-opcode exception (`exc_code` = 2). This check has the highest priority and overrides every other condition.
- R4: In virtual-8086 mode (`v86_mode` = 1) without a lock prefix, the request always raises general-protection (`exc_code` = 1) with `exc_err` = 0, whatever the privilege level or real-mode flag. Every general-protection report carries `exc_err` = 0.
- R5: When neither lock nor virtual-8086 applies, a request with `priv` not equal to 0 and `real_mode` = 0 raises general-protection (`exc_code` = 1).
- R6: An index whose low 32 bits match no entry of the address table raises general-protection in every mode, real-address mode included. This check has the lowest priority.
- R7: In real-address mode the read succeeds at any privilege level, provided the address is implemented and neither lock nor virtual-8086 applies.
- R8: When a request raises an exception, `rd_hi` and `rd_lo` keep the values from the last successful read (zero after reset).
- R9: The outcome appears on the clock edge after the edge that samples `req`. `done` pulses for one cycle per request and is low otherwise. Whenever `done` is high, exactly one of `res_vld` and `exc_vld` is high.
- R10: While `pl_we` = 1, a rising edge stores `pl_data` ANDed with the slot's implemented-bits mask into slot `pl_slot`. With the default tables, slots 0 to 7 sit at 0x00000000, 0x00000001, 0x00000100, 0x00000FFF, 0x80000000, 0xC0000080, 0xFFFFFFFE and 0xFFFFFFFF. Slot 6 implements bits 47:0, slot 7 implements bits 15:0, and all other slots implement all 64 bits.
- R11: During and after reset, `done`, `res_vld`, `exc_vld`, `exc_code`, `rd_hi`, `rd_lo` and all bank slots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request strobe |
| index | input | 64 | Index operand; only the low 32 bits are used |
| priv | input | 2 | Current privilege level |
| real_mode | input | 1 | Core is in real-address mode |
| v86_mode | input | 1 | Core is in virtual-8086 mode |
| lock_pfx | input | 1 | Request carries a lock prefix |
| pl_we | input | 1 | Preload write enable |
| pl_slot | input | 3 | Preload target slot |
| pl_data | input | 64 | Preload value |
| done | output | 1 | One-cycle completion pulse |
| res_vld | output | 1 | Completion is a successful read |
| exc_vld | output | 1 | Completion is an exception |
| exc_code | output | 2 | 0 none, 1 general-protection, 2 invalid-opcode |
| exc_err | output | 16 | Error code of the exception (zero) |
| rd_hi | output | 64 | High-half destination, zero-extended |
| rd_lo | output | 64 | Low-half destination, zero-extended |

## Verification
The bench sweeps every combination of privilege, real, virtual-8086 and lock flags against every table address and a set of near-miss addresses. It puts non-zero bits in the ignored upper index half. These sweeps catch a wrong fault ordering, which would report general-protection where a lock prefix should have given invalid-opcode, and catch a decoder that compares more than 32 bits, which would miss valid registers. The partially implemented slots and a re-write of slot 0 expose a missing mask or a stale value. Checking the destinations after every faulting request catches a design that writes results while it also raises an exception.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

   typedef enum logic [1:0] {
      EXC_NONE  = 2'd0,
      EXC_PROT  = 2'd1,
      EXC_BADOP = 2'd2
   } exc_e;

   localparam int unsigned EXC_ERR_W = 16;

endpackage

// File: rtl/mrr_bank.sv
module mrr_bank #(
   parameter int unsigned NUM_REGS     = 8,
   parameter int unsigned REG_W        = 64,
   parameter int unsigned ADDR_W       = 32,
   parameter bit          MATCH_ONEHOT = 1'b1,
   parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDRS  = '0,
   parameter logic [NUM_REGS*REG_W-1:0]  IMPL_MASKS = '1,
   localparam int unsigned SLOT_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SLOT_W-1:0] wslot,
   input  logic [REG_W-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic              hit,
   output logic [REG_W-1:0]  rdata
);

   logic [REG_W-1:0]    mem [NUM_REGS];
   logic [NUM_REGS-1:0] match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
      end else if (we && (32'(wslot) < NUM_REGS)) begin
         mem[wslot] <= wdata & IMPL_MASKS[wslot*REG_W +: REG_W];
      end
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
      assign match[g] = (raddr == REG_ADDRS[g*ADDR_W +: ADDR_W]);
   end

   assign hit = |match;

   if (MATCH_ONEHOT) begin : g_andor
      always_comb begin
         rdata = '0;
         for (int i = 0; i < NUM_REGS; i++) begin
            rdata = rdata | (mem[i] & {REG_W{match[i]}});
         end
      end
   end else begin : g_prio
      always_comb begin
         rdata = '0;
         for (int i = NUM_REGS - 1; i >= 0; i--) begin
            if (match[i]) rdata = mem[i];
         end
      end
   end

endmodule

// File: rtl/mrr_fault.sv
module mrr_fault
   import mrr_pkg::*;
#(
   parameter int unsigned PRIV_W = 2
) (
   input  logic              lock_pfx,
   input  logic              v86_mode,
   input  logic              real_mode,
   input  logic [PRIV_W-1:0] priv,
   input  logic              hit,
   output exc_e              exc
);

   always_comb begin
      if (lock_pfx)                        exc = EXC_BADOP;
      else if (v86_mode)                   exc = EXC_PROT;
      else if ((priv != '0) && !real_mode) exc = EXC_PROT;
      else if (!hit)                       exc = EXC_PROT;
      else                                 exc = EXC_NONE;
   end

endmodule

// File: rtl/mrr_read_unit.sv
module mrr_read_unit
   import mrr_pkg::*;
#(
   parameter int unsigned NUM_REGS     = 8,
   parameter int unsigned REG_W        = 64,
   parameter int unsigned IDX_W        = 64,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned PRIV_W       = 2,
   parameter bit          MATCH_ONEHOT = 1'b1,
   parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDRS = {
      32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hC000_0080, 32'h8000_0000,
      32'h0000_0FFF, 32'h0000_0100, 32'h0000_0001, 32'h0000_0000},
   parameter logic [NUM_REGS*REG_W-1:0] IMPL_MASKS = {
      64'h0000_0000_0000_FFFF, 64'h0000_FFFF_FFFF_FFFF,
      {6{64'hFFFF_FFFF_FFFF_FFFF}}},
   localparam int unsigned SLOT_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int unsigned HALF_W = REG_W / 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic [IDX_W-1:0]     index,
   input  logic [PRIV_W-1:0]    priv,
   input  logic                 real_mode,
   input  logic                 v86_mode,
   input  logic                 lock_pfx,
   input  logic                 pl_we,
   input  logic [SLOT_W-1:0]    pl_slot,
   input  logic [REG_W-1:0]     pl_data,
   output logic                 done,
   output logic                 res_vld,
   output logic                 exc_vld,
   output logic [1:0]           exc_code,
   output logic [EXC_ERR_W-1:0] exc_err,
   output logic [REG_W-1:0]     rd_hi,
   output logic [REG_W-1:0]     rd_lo
);

   initial begin : p_param_chk
      if (REG_W % 2 != 0)   $error("REG_W must be even");
      if (IDX_W <= ADDR_W)  $error("IDX_W must exceed ADDR_W");
      if (NUM_REGS < 1)     $error("NUM_REGS must be at least 1");
   end

   logic             hit;
   logic [REG_W-1:0] rdata;
   exc_e             exc;
   logic             unused_idx_hi;

   assign unused_idx_hi = ^index[IDX_W-1:ADDR_W];

   mrr_bank #(
      .NUM_REGS    (NUM_REGS),
      .REG_W       (REG_W),
      .ADDR_W      (ADDR_W),
      .MATCH_ONEHOT(MATCH_ONEHOT),
      .REG_ADDRS   (REG_ADDRS),
      .IMPL_MASKS  (IMPL_MASKS)
   ) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (pl_we),
      .wslot(pl_slot),
      .wdata(pl_data),
      .raddr(index[ADDR_W-1:0]),
      .hit  (hit),
      .rdata(rdata)
   );

   mrr_fault #(
      .PRIV_W(PRIV_W)
   ) u_fault (
      .lock_pfx (lock_pfx),
      .v86_mode (v86_mode),
      .real_mode(real_mode),
      .priv     (priv),
      .hit      (hit),
      .exc      (exc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         res_vld  <= 1'b0;
         exc_vld  <= 1'b0;
         exc_code <= EXC_NONE;
         rd_hi    <= '0;
         rd_lo    <= '0;
      end else begin
         done     <= req;
         res_vld  <= req && (exc == EXC_NONE);
         exc_vld  <= req && (exc != EXC_NONE);
         exc_code <= req ? exc : EXC_NONE;
         if (req && (exc == EXC_NONE)) begin
            rd_hi <= {{(REG_W-HALF_W){1'b0}}, rdata[REG_W-1:HALF_W]};
            rd_lo <= {{(REG_W-HALF_W){1'b0}}, rdata[HALF_W-1:0]};
         end
      end
   end

   assign exc_err = '0;

endmodule

// File: rtl/mrr_read_checker.sv
module mrr_read_checker #(
   parameter int unsigned REG_W  = 64,
   parameter int unsigned PRIV_W = 2,
   localparam int unsigned HALF_W = REG_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic [PRIV_W-1:0] priv,
   input logic              real_mode,
   input logic              v86_mode,
   input logic              lock_pfx,
   input logic              done,
   input logic              res_vld,
   input logic              exc_vld,
   input logic [1:0]        exc_code,
   input logic [REG_W-1:0]  rd_hi,
   input logic [REG_W-1:0]  rd_lo
);

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (res_vld != exc_vld)); // R9

   AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> done); // R9

   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !done); // R9

   AST_LOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (req && lock_pfx) |=> (exc_vld && exc_code == 2'd2)); // R3

   AST_V86_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !lock_pfx && v86_mode) |=> (exc_vld && exc_code == 2'd1)); // R4

   AST_PRIV_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !lock_pfx && !v86_mode && !real_mode && priv != '0)
         |=> (exc_vld && exc_code == 2'd1)); // R5

   AST_HOLD_ON_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      exc_vld |-> ($stable(rd_hi) && $stable(rd_lo))); // R8

   AST_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (rd_hi[REG_W-1:HALF_W] == '0 && rd_lo[REG_W-1:HALF_W] == '0)); // R2

endmodule

bind mrr_read_unit mrr_read_checker #(
   .REG_W (REG_W),
   .PRIV_W(PRIV_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req      (req),
   .priv     (priv),
   .real_mode(real_mode),
   .v86_mode (v86_mode),
   .lock_pfx (lock_pfx),
   .done     (done),
   .res_vld  (res_vld),
   .exc_vld  (exc_vld),
   .exc_code (exc_code),
   .rd_hi    (rd_hi),
   .rd_lo    (rd_lo)
);

// File: tb/tb_mrr_read_unit.sv
`timescale 1ns/1ps
module tb_mrr_read_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [63:0] index = '0;
   logic [1:0]  priv = '0;
   logic        real_mode = 1'b0;
   logic        v86_mode = 1'b0;
   logic        lock_pfx = 1'b0;
   logic        pl_we = 1'b0;
   logic [2:0]  pl_slot = '0;
   logic [63:0] pl_data = '0;
   logic        done, res_vld, exc_vld;
   logic [1:0]  exc_code;
   logic [15:0] exc_err;
   logic [63:0] rd_hi, rd_lo;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   logic [31:0] b_addr [8];
   logic [63:0] b_mask [8];
   logic [63:0] b_val  [8];
   logic [63:0] last_hi = '0;
   logic [63:0] last_lo = '0;

   always #2 clk = ~clk;

   mrr_read_unit dut (
      .clk(clk), .rst_n(rst_n), .req(req), .index(index), .priv(priv),
      .real_mode(real_mode), .v86_mode(v86_mode), .lock_pfx(lock_pfx),
      .pl_we(pl_we), .pl_slot(pl_slot), .pl_data(pl_data),
      .done(done), .res_vld(res_vld), .exc_vld(exc_vld), .exc_code(exc_code),
      .exc_err(exc_err), .rd_hi(rd_hi), .rd_lo(rd_lo)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000 && !finished) begin
         errors++;
         $display("FAIL R9 watchdog actual=%h expected=%h", 64'd0, 64'd1);
         summary();
         $finish;
      end
   end

   task automatic preload(input int s, input logic [63:0] d);
      @(negedge clk);
      pl_we = 1'b1; pl_slot = 3'(s); pl_data = d;
      @(negedge clk);
      pl_we = 1'b0;
      b_val[s] = d & b_mask[s];
   endtask

   task automatic do_req(input logic [63:0] idx, input logic [1:0] pr,
                         input bit rm, input bit vm, input bit lk);
      bit          hit = 1'b0;
      int          slot = 0;
      logic [1:0]  ecode;
      string       tag;
      for (int i = 0; i < 8; i++) begin
         if (b_addr[i] == idx[31:0]) begin hit = 1'b1; slot = i; end
      end
      if (lk)                     begin ecode = 2'd2; tag = "R3"; end
      else if (vm)                begin ecode = 2'd1; tag = "R4"; end
      else if (pr != 0 && !rm)    begin ecode = 2'd1; tag = "R5"; end
      else if (!hit)              begin ecode = 2'd1; tag = "R6"; end
      else begin
         ecode = 2'd0;
         if (slot >= 6)               tag = "R10";
         else if (rm && pr != 0)      tag = "R7";
         else                         tag = "R1";
      end
      @(negedge clk);
      req = 1'b1; index = idx; priv = pr; real_mode = rm; v86_mode = vm; lock_pfx = lk;
      @(negedge clk);
      req = 1'b0;
      chk(done == 1'b1, "R9", "done pulse", 64'(done), 64'd1);
      chk(exc_code == ecode, tag, "exc_code", 64'(exc_code), 64'(ecode));
      chk(exc_vld == (ecode != 0), tag, "exc_vld", 64'(exc_vld), 64'(ecode != 0));
      chk(res_vld == (ecode == 0), tag, "res_vld", 64'(res_vld), 64'(ecode == 0));
      if (ecode != 0) begin
         if (ecode == 2'd1) chk(exc_err == 16'd0, "R4", "exc_err", 64'(exc_err), 64'd0);
         chk(rd_hi == last_hi, "R8", "rd_hi held", rd_hi, last_hi);
         chk(rd_lo == last_lo, "R8", "rd_lo held", rd_lo, last_lo);
      end else begin
         last_hi = {32'd0, b_val[slot][63:32]};
         last_lo = {32'd0, b_val[slot][31:0]};
         chk(rd_hi == last_hi, tag, "rd_hi", rd_hi, last_hi);
         chk(rd_lo == last_lo, tag, "rd_lo", rd_lo, last_lo);
         chk(rd_hi[63:32] == 32'd0 && rd_lo[63:32] == 32'd0, "R2", "upper zero",
             {rd_hi[63:32], rd_lo[63:32]}, 64'd0);
      end
      @(negedge clk);
      chk(done == 1'b0 && res_vld == 1'b0 && exc_vld == 1'b0, "R9", "idle after pulse",
          64'({done, res_vld, exc_vld}), 64'd0);
   endtask

   initial begin
      logic [31:0] miss [4];
      b_addr[0] = 32'h0000_0000; b_addr[1] = 32'h0000_0001;
      b_addr[2] = 32'h0000_0100; b_addr[3] = 32'h0000_0FFF;
      b_addr[4] = 32'h8000_0000; b_addr[5] = 32'hC000_0080;
      b_addr[6] = 32'hFFFF_FFFE; b_addr[7] = 32'hFFFF_FFFF;
      for (int i = 0; i < 8; i++) begin
         b_mask[i] = 64'hFFFF_FFFF_FFFF_FFFF;
         b_val[i]  = '0;
      end
      b_mask[6] = 64'h0000_FFFF_FFFF_FFFF;
      b_mask[7] = 64'h0000_0000_0000_FFFF;
      miss[0] = 32'h0000_0002; miss[1] = 32'h0000_1000;
      miss[2] = 32'h7FFF_FFFF; miss[3] = 32'hFFFF_FFFD;

      repeat (3) @(negedge clk);
      chk({done, res_vld, exc_vld} == 3'b000, "R11", "flags in reset", 64'({done, res_vld, exc_vld}), 64'd0);
      chk(rd_hi == 64'd0 && rd_lo == 64'd0, "R11", "dest in reset", rd_hi | rd_lo, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(exc_code == 2'd0 && done == 1'b0, "R11", "after reset", 64'({exc_code, done}), 64'd0);

      // R11: slots read zero after reset
      do_req({32'hDEAD_BEEF, b_addr[3]}, 2'd0, 1'b0, 1'b0, 1'b0);

      for (int s = 0; s < 8; s++)
         preload(s, {32'hA5C3_0000 + 32'(s * 32'h0101_1111), 32'h1234_5678 ^ 32'(s * 32'h9E37_79B9)});

      for (int s = 0; s < 8; s++) begin
         for (int c = 0; c < 32; c++) begin
            do_req({32'(s * 32'h1357_9BDF + c * 32'h0F0F_1234 + 1), b_addr[s]},
                   2'(c), c[2], c[3], c[4]);
         end
      end

      for (int m = 0; m < 4; m++) begin
         for (int c = 0; c < 32; c++) begin
            do_req({32'(m * 32'h2468_ACE1 + c + 1), miss[m]}, 2'(c), c[2], c[3], c[4]);
         end
      end

      // R10: overwrite slot 0 then read it back, also in real mode (R7)
      preload(0, 64'hFFFF_0000_8000_0001);
      do_req({32'hFFFF_FFFF, b_addr[0]}, 2'd0, 1'b0, 1'b0, 1'b0);
      preload(7, 64'hFFFF_FFFF_FFFF_FFFF);
      do_req({32'h0000_0001, b_addr[7]}, 2'd3, 1'b1, 1'b0, 1'b0);
      // R8: fault right after success keeps destinations
      do_req({32'h0, b_addr[2]}, 2'd1, 1'b0, 1'b0, 1'b0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule